// File: doc/BRIEF.md
# Compare-Match Deadline Timer

This block is one per-core deadline timer. It watches a shared 64-bit system count that only counts up, and it raises a level interrupt once that count has reached a programmed deadline. Software can see the deadline in two ways. One is an absolute 64-bit compare value. The other is a 32-bit relative value: the distance from the current count to the deadline. Both views map onto the same storage, so writing either one moves the same deadline.

A 64-bit offset register can be subtracted from the incoming physical count. This lets the block act as a virtual timer. With the offset held at zero, or with the offset option turned off by parameter, it behaves as a physical timer. Every register change takes effect at once. The firing condition is evaluated every cycle from the stored registers and the present count. The interrupt line is a registered copy of the gated condition.

Register selects (`wr_sel`, `rd_sel`): 0 = control, 1 = absolute compare, 2 = relative value, 3 = offset, 4..7 unused.

Top module: `cmp_deadline_timer`

## Requirements
- R1: After reset the control bits are 0, the compare value is 0, the offset is 0 and `irq` is 0.
- R2: The control register reads as bit 0 = enable, bit 1 = mask, bit 2 = status, with bits 63..3 reading 0. A write stores only bits 0 and 1; writing bit 2 has no effect.
- R3: A write to select 1 stores all 64 bits of `wr_data` as the compare value, and a read of select 1 returns it.
- R4: The status bit is 1 exactly when enable is 1 and the timer count is greater than or equal to the compare value, compared unsigned in 64 bits.
- R5: A read of select 2 returns (compare − timer count) modulo 2^32 in bits 31..0, with bits 63..32 reading 0.
- R6: A write to select 2 sets the compare value to the timer count plus `wr_data[31:0]` sign-extended to 64 bits, modulo 2^64.
- R7: The timer count is `sys_count` minus the offset, modulo 2^64. A write to select 3 stores the offset, and a read of select 3 returns it.
- R8: `irq` in each cycle equals enable AND status AND NOT mask, as they stood at the previous rising clock edge. It therefore follows any register write or count change one cycle later.
- R9: While enable is 0, status reads 0 and `irq` stays 0, but the compare value keeps its contents.
- R10: Writes to selects 4..7 change no register, and reads of selects 4..7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Shared physical up-count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 64 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 64 | Read data, combinational from `rd_sel` |
| irq | output | 1 | Level interrupt |

## Verification
The bench sets compare values at, just above and just below the timer count, where an off-by-one comparator would fire one count early or one count late. It also moves the count across the top of the 64-bit range, where a signed comparison would give the wrong answer. Negative relative writes and offsets larger than the physical count test the wrap arithmetic: a design that zero-extends the relative value, or saturates instead of wrapping, would place the deadline far from where it belongs. Toggling mask and enable with the deadline already passed shows whether `irq` drops one cycle later and whether the compare value survives while the timer is disabled.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_CMP  = 3'd1,
    SEL_REL  = 3'd2,
    SEL_OFS  = 3'd3
  } cdt_sel_e;

  typedef struct packed {
    logic mask;
    logic en;
  } cdt_ctrl_t;
endpackage

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg
  import cdt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output cdt_ctrl_t         ctrl_q
);
  logic hit;
  assign hit = wr_en && (wr_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hit) begin
      ctrl_q.en   <= wr_data[0];
      ctrl_q.mask <= wr_data[1];
    end
  end
endmodule

// File: rtl/cdt_match.sv
module cdt_match #(
  parameter int CNT_W = 64,
  parameter int REL_W = 32
) (
  input  logic [CNT_W-1:0] sys_count,
  input  logic [CNT_W-1:0] ofs_q,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic             en,
  output logic [CNT_W-1:0] vcount,
  output logic [REL_W-1:0] rel_view,
  output logic             cond_met
);
  function automatic logic [CNT_W-1:0] virt_of(input logic [CNT_W-1:0] phys,
                                               input logic [CNT_W-1:0] ofs);
    return phys - ofs;
  endfunction

  function automatic logic [REL_W-1:0] dist_of(input logic [CNT_W-1:0] cmp,
                                               input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] diff;
    diff = cmp - cnt;
    return diff[REL_W-1:0];
  endfunction

  function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] cmp);
    return cnt >= cmp;
  endfunction

  assign vcount   = virt_of(sys_count, ofs_q);
  assign rel_view = dist_of(cmp_q, vcount);
  assign cond_met = en && reached(vcount, cmp_q);
endmodule

// File: rtl/cdt_deadline_reg.sv
module cdt_deadline_reg
  import cdt_pkg::*;
#(
  parameter int CNT_W      = 64,
  parameter int REL_W      = 32,
  parameter bit HAS_OFFSET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] vcount,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] ofs_q
);
  localparam int EXT_W = CNT_W - REL_W;

  function automatic logic [CNT_W-1:0] rel_to_abs(input logic [CNT_W-1:0] cnt,
                                                  input logic [REL_W-1:0] rel);
    return cnt + {{EXT_W{rel[REL_W-1]}}, rel};
  endfunction

  logic cmp_hit, rel_hit, ofs_hit;
  assign cmp_hit = wr_en && (wr_sel == SEL_CMP);
  assign rel_hit = wr_en && (wr_sel == SEL_REL);
  assign ofs_hit = wr_en && (wr_sel == SEL_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_hit) begin
      cmp_q <= wr_data;
    end else if (rel_hit) begin
      cmp_q <= rel_to_abs(vcount, wr_data[REL_W-1:0]);
    end
  end

  generate
    if (HAS_OFFSET) begin : g_ofs
      always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= '0;
        else if (ofs_hit) ofs_q <= wr_data;
      end
    end else begin : g_no_ofs
      assign ofs_q = '0;
    end
  endgenerate
endmodule

// File: rtl/cmp_deadline_timer.sv
module cmp_deadline_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W      = 64,
  parameter int REL_W      = 32,
  parameter bit HAS_OFFSET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] sys_count,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  localparam int CTRL_PAD = CNT_W - 3;
  localparam int REL_PAD  = CNT_W - REL_W;

  cdt_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cmp_q, ofs_q, vcount;
  logic [REL_W-1:0] rel_view;
  logic             cond_met;
  logic             fire_next;

  cdt_ctrl_reg #(.DATA_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  cdt_deadline_reg #(.CNT_W(CNT_W), .REL_W(REL_W), .HAS_OFFSET(HAS_OFFSET)) u_dl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .vcount(vcount), .cmp_q(cmp_q), .ofs_q(ofs_q)
  );

  cdt_match #(.CNT_W(CNT_W), .REL_W(REL_W)) u_match (
    .sys_count(sys_count), .ofs_q(ofs_q), .cmp_q(cmp_q), .en(ctrl_q.en),
    .vcount(vcount), .rel_view(rel_view), .cond_met(cond_met)
  );

  assign fire_next = cond_met && !ctrl_q.mask;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire_next;
  end

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: rd_data = {{CTRL_PAD{1'b0}}, cond_met, ctrl_q.mask, ctrl_q.en};
      SEL_CMP:  rd_data = cmp_q;
      SEL_REL:  rd_data = {{REL_PAD{1'b0}}, rel_view};
      SEL_OFS:  rd_data = ofs_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int CNT_W = 64,
  parameter int REL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic [2:0]       rd_sel,
  input logic [CNT_W-1:0] rd_data,
  input logic             irq,
  input logic             ctrl_en,
  input logic             ctrl_mask,
  input logic             cond_met,
  input logic [CNT_W-1:0] vcount,
  input logic [CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] ofs_q
);
  localparam int EXT_W = CNT_W - REL_W;

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == ($past(ctrl_en) && $past(cond_met) && !$past(ctrl_mask)));

  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !cond_met);

  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd0) |-> (rd_data[CNT_W-1:3] == '0));

  a_r3_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd1) |=> cmp_q == $past(wr_data));

  a_r6_rel_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2) |=>
      cmp_q == $past(vcount) + {{EXT_W{$past(wr_data[REL_W-1])}}, $past(wr_data[REL_W-1:0])});

  a_r10_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[2]) |=> ($stable(cmp_q) && $stable(ofs_q) &&
                              $stable(ctrl_en) && $stable(ctrl_mask)));

  a_r4_status_needs_reach: assert property (@(posedge clk) disable iff (!rst_n)
    cond_met |-> (vcount >= cmp_q));
endmodule

bind cmp_deadline_timer cdt_checker #(.CNT_W(CNT_W), .REL_W(REL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .ctrl_en(ctrl_q.en),
  .ctrl_mask(ctrl_q.mask), .cond_met(cond_met), .vcount(vcount),
  .cmp_q(cmp_q), .ofs_q(ofs_q)
);

// File: tb/sim_cmp_deadline_timer.sv
module sim_cmp_deadline_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the programmed state
  logic        m_en = 1'b0, m_mask = 1'b0;
  logic [63:0] m_cmp = '0, m_ofs = '0;

  always #4 clk = ~clk;

  cmp_deadline_timer u0 (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq)
  );

  function automatic logic [63:0] t_count();
    return sys_count + (~m_ofs + 64'd1);
  endfunction

  function automatic logic e_status();
    logic [64:0] d;
    d = {1'b0, t_count()} - {1'b0, m_cmp};
    return m_en && !d[64];
  endfunction

  function automatic logic [63:0] e_rel();
    logic [63:0] d;
    d = m_cmp + ~t_count() + 64'd1;
    return {32'd0, d[31:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [63:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    case (s)
      3'd0: begin m_en = d[0]; m_mask = d[1]; end
      3'd1: m_cmp = d;
      3'd2: m_cmp = t_count() + {{32{d[31]}}, d[31:0]};
      3'd3: m_ofs = d;
      default: ;
    endcase
  endtask

  task automatic set_cnt(input logic [63:0] c);
    @(negedge clk);
    sys_count = c;
  endtask

  // one edge lets irq catch up, then compare every view
  task automatic settle_check(input string ctx);
    logic [63:0] v;
    @(posedge clk);
    @(negedge clk);
    check({ctx, " R8 irq"}, {63'd0, irq}, {63'd0, m_en && e_status() && !m_mask});
    rd(3'd0, v);
    check({ctx, " R2 R4 R9 ctrl"}, v, {61'd0, e_status(), m_mask, m_en});
    rd(3'd1, v);
    check({ctx, " R3 cmp"}, v, m_cmp);
    rd(3'd2, v);
    check({ctx, " R5 rel"}, v, e_rel());
    rd(3'd3, v);
    check({ctx, " R7 ofs"}, v, m_ofs);
  endtask

  initial begin : watchdog
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {63'd0, irq}, 64'd0);
    rd(3'd0, v); check("R1 ctrl", v, 64'd0);
    rd(3'd1, v); check("R1 cmp", v, 64'd0);
    rd(3'd3, v); check("R1 ofs", v, 64'd0);
    rst_n = 1'b1;

    // R4 equality boundary
    set_cnt(64'd1000);
    wr(3'd1, 64'd1001); wr(3'd0, 64'h1); settle_check("R4 one below");
    set_cnt(64'd1001); settle_check("R4 equal");
    set_cnt(64'd1002); settle_check("R4 past");
    // R2 status bit not writable, upper bits ignored
    wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFC); settle_check("R2 status write");
    // R8 mask gate
    wr(3'd0, 64'h3); settle_check("R8 masked");
    wr(3'd0, 64'h1); settle_check("R8 unmasked");
    // R9 disable keeps compare
    wr(3'd0, 64'h0); settle_check("R9 disabled");
    // R4 unsigned at top of range
    set_cnt(64'hFFFF_FFFF_FFFF_FFF0); wr(3'd1, 64'h0); wr(3'd0, 64'h1);
    settle_check("R4 unsigned top");
    wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFF); settle_check("R4 max cmp");
    // R6 negative relative, R7 offset above count
    wr(3'd2, 64'h0000_0000_FFFF_FFF0); settle_check("R6 neg rel");
    set_cnt(64'd5); wr(3'd3, 64'd100); settle_check("R7 wrap ofs");
    wr(3'd2, 64'h0000_0000_0000_0010); settle_check("R6 pos rel");
    // R10 unused selects
    for (int s = 4; s < 8; s++) begin
      wr(s[2:0], 64'hDEAD_BEEF_0123_4567);
      rd(s[2:0], v); check("R10 read zero", v, 64'd0);
    end
    settle_check("R10 no change");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [63:0] r;
      op = $urandom_range(0, 5);
      r = {$urandom(), $urandom()};
      case (op)
        0: wr(3'd0, {61'd0, r[2:0]});
        1: wr(3'd1, t_count() + {{54{r[9]}}, r[9:0]});
        2: wr(3'd2, {32'd0, {{22{r[40]}}, r[41:32]}});
        3: wr(3'd3, (i % 7 == 0) ? r : {56'd0, r[7:0]});
        4: set_cnt(sys_count + {60'd0, r[3:0]});
        default: wr($urandom_range(4, 7), r);
      endcase
      settle_check("rand");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule